// File: doc/BRIEF.md
# Event Source Pending/Queued State Controller

This block holds a two-bit state for each of a bank of interrupt sources: P (pending) and Q (queued). It coalesces triggers, so that a source is forwarded to the downstream router at most once until software acknowledges it with an end-of-interrupt (EOI). A trigger that arrives while P is set only records itself in Q. An EOI taken while Q is set forwards the source again.

Triggers come from per-source hardware pulses, or from a level input on sources built as level-sensitive. They can also come from stores through a load/store port. Each source owns an address page, and the low offset bits of an access select its effect: EOI, read, inject, or force the state to a given value. Every load returns the state the source held before the access. Forwarded sources leave through a valid/ready notify port that carries the source number.

The page size is a parameter. Two of its settings split each page into a trigger half and a management half.

Top module: `evsrc_pq_ctrl`

## Requirements
- R1: After reset every source holds the state given by parameter RESET_PQ, the asserted flag is 0, and notify_valid_o is 0. State bits are P at bit 1 and Q at bit 0; reads return {asserted, P, Q} on bits 2..0.
- R2: A trigger moves state 00 to 10 and forwards the source. It moves 10 to 11 without forwarding. States 11 and 01 are left as they are, with no forwarding.
- R3: A load at page offset 0x000 is an EOI. It moves 10 to 00, and moves 11 to 10 while forwarding the source again. States 00 and 01 are unchanged. The load returns the prior state.
- R4: A load at offset 0x800 returns the prior state and changes nothing.
- R5: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 force the state to 00, 01, 10 and 11 respectively. They never forward the source, and they return the prior state.
- R6: A store at offset 0x800 acts as a trigger. A store at offset 0x400 acts as an EOI only when STORE_EOI is 1, and is ignored otherwise.
- R7: The source number is addr[ADDR_W-1:PAGE_SHIFT] and the offset is addr[11:0]. When PAGE_SHIFT is 13 or 17, addr[PAGE_SHIFT-1]=0 selects the trigger page: any store there triggers and any load there only reads. addr[PAGE_SHIFT-1]=1 selects the management page, which decodes the offsets above.
- R8: notify_valid_o and notify_src_o hold steady while notify_ready_i is low. When several sources are waiting, the lowest source number is sent first, and each forwarding is sent once.
- R9: When a hardware trigger and a port access hit the same source in the same cycle, the access is applied first and the trigger is applied to its result.
- R10: On sources marked in LEVEL_MASK, trig_i is ignored. The asserted flag follows level_i one cycle later, and a rising level acts as a trigger. An EOI that leaves P clear while the flag is still set triggers again.
- R11: Load data and bus_rvalid_o appear in the cycle after the access. A forwarding shows on notify_valid_o two clock edges after the triggering input is sampled.
- R12: Stores at any offset other than 0x400 or 0x800 on the management page are ignored. Loads whose offset bits [11:10] are 01 act as plain reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | NUM_SRC | One-cycle trigger pulse per edge source |
| level_i | input | NUM_SRC | Input level per level-sensitive source |
| bus_req_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = store, 0 = load |
| bus_addr_i | input | ADDR_W | Byte address: source page and offset |
| bus_rdata_o | output | 3 | Prior {asserted, P, Q} of the loaded source |
| bus_rvalid_o | output | 1 | Load data valid |
| notify_valid_o | output | 1 | A source is being forwarded |
| notify_src_o | output | SRC_W | Number of the forwarded source |
| notify_ready_i | input | 1 | Router accepts the forwarded source |

## Verification
Load data is registered on the same edge that updates the state. The bench drives each access at a falling edge and samples the returned value at the next falling edge, exactly one clock edge later. A forwarding passes through two registers: the per-source state with its waiting flag, and then the output register. The trigger-timing test therefore checks that notify_valid_o is still low after the first edge and high with the right source number after the second. Other tests count accepted forwardings at the port after several idle cycles. The results of same-cycle collisions are checked through a following read, because only the final state and the forwarding count tell the two possible orderings apart.

// File: rtl/evsrc_pkg.sv
package evsrc_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_GET,
    OP_EOI,
    OP_SET,
    OP_INJ
  } evsrc_op_e;

  localparam logic [1:0] PQ_IDLE = 2'b00;
  localparam logic [1:0] PQ_OFF  = 2'b01;
  localparam logic [1:0] PQ_PEND = 2'b10;
  localparam logic [1:0] PQ_QUED = 2'b11;

  // returns {forward, next_state}
  function automatic logic [2:0] pq_trigger(logic [1:0] pq);
    case (pq)
      PQ_IDLE: pq_trigger = {1'b1, PQ_PEND};
      PQ_PEND: pq_trigger = {1'b0, PQ_QUED};
      default: pq_trigger = {1'b0, pq};
    endcase
  endfunction

  function automatic logic [2:0] pq_eoi(logic [1:0] pq);
    case (pq)
      PQ_PEND: pq_eoi = {1'b0, PQ_IDLE};
      PQ_QUED: pq_eoi = {1'b1, PQ_PEND};
      default: pq_eoi = {1'b0, pq};
    endcase
  endfunction
endpackage

// File: rtl/evsrc_decode.sv
module evsrc_decode
  import evsrc_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int PAGE_SHIFT = 16,
  parameter bit STORE_EOI  = 1'b1,
  parameter int SRC_W      = 3,
  parameter int ADDR_W     = 19
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SRC_W-1:0]  src_o,
  output evsrc_op_e         op_o,
  output logic [1:0]        set_val_o
);
  localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

  logic [11:0] off;
  logic        mgmt_page;
  wire         unused_addr = ^addr_i;

  assign off       = addr_i[11:0];
  assign src_o     = addr_i[ADDR_W-1:PAGE_SHIFT];
  assign hit_o     = req_i && (int'(src_o) < NUM_SRC);
  assign set_val_o = off[9:8];

  generate
    if (TWO_PAGE) begin : g_two_page
      assign mgmt_page = addr_i[PAGE_SHIFT-1];
    end else begin : g_one_page
      assign mgmt_page = 1'b1;
    end
  endgenerate

  always_comb begin
    op_o = OP_NONE;
    if (hit_o) begin
      if (!mgmt_page) begin
        op_o = we_i ? OP_INJ : OP_GET;
      end else if (we_i) begin
        case (off[11:10])
          2'b01:   op_o = STORE_EOI ? OP_EOI : OP_NONE;
          2'b10:   op_o = OP_INJ;
          default: op_o = OP_NONE;
        endcase
      end else begin
        case (off[11:10])
          2'b00:   op_o = OP_EOI;
          2'b11:   op_o = OP_SET;
          default: op_o = OP_GET;
        endcase
      end
    end
  end
endmodule

// File: rtl/evsrc_cell.sv
module evsrc_cell
  import evsrc_pkg::*;
#(
  parameter logic [1:0] RESET_PQ = 2'b00,
  parameter bit         IS_LEVEL = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  evsrc_op_e  op_i,
  input  logic [1:0] set_val_i,
  input  logic       trig_i,
  input  logic       level_i,
  output logic [2:0] state_o,
  output logic       notify_o
);
  logic [1:0] pq_q, step1, step2;
  logic       asrt_q, n1, n2, hw_trig;

  always_comb begin
    step1 = pq_q;
    n1    = 1'b0;
    case (op_i)
      OP_EOI:  {n1, step1} = pq_eoi(pq_q);
      OP_SET:  step1 = set_val_i;
      OP_INJ:  {n1, step1} = pq_trigger(pq_q);
      default: ;
    endcase
    // access first, then the hardware trigger on its result
    hw_trig = IS_LEVEL ? ((level_i & ~asrt_q) |
                          ((op_i == OP_EOI) & asrt_q & ~step1[1]))
                       : trig_i;
    step2 = step1;
    n2    = 1'b0;
    if (hw_trig) {n2, step2} = pq_trigger(step1);
    notify_o = n1 | n2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pq_q   <= RESET_PQ;
      asrt_q <= 1'b0;
    end else begin
      pq_q   <= step2;
      asrt_q <= IS_LEVEL ? level_i : 1'b0;
    end
  end

  assign state_o = {asrt_q, pq_q};

  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pq_q == PQ_OFF && op_i != OP_SET) |-> !notify_o); // R2
  AST_FORWARD_LEAVES_P: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |=> pq_q[1]); // R2
  AST_QUEUED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pq_q == PQ_QUED && (op_i == OP_NONE || op_i == OP_GET)) |=> pq_q == PQ_QUED); // R2
  AST_EOI_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_EOI && pq_q == PQ_QUED) |-> notify_o); // R3
  AST_SET_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SET && !trig_i && !IS_LEVEL) |=> pq_q == $past(set_val_i)); // R5
endmodule

// File: rtl/evsrc_notify_arb.sv
module evsrc_notify_arb #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] new_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [SRC_W-1:0]   src_o
);
  logic [NUM_SRC-1:0] pend_q, grant;
  logic [SRC_W-1:0]   sel;
  logic               found, take, valid_q;
  logic [SRC_W-1:0]   src_q;

  assign take = !valid_q || ready_i;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_q[i] && !found) begin
        sel   = SRC_W'(i);
        found = 1'b1;
      end
    end
    grant = '0;
    if (take && found) grant[sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      src_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~grant) | new_i;
      if (take) begin
        valid_q <= found;
        if (found) src_q <= sel;
      end
    end
  end

  assign valid_o = valid_q;
  assign src_o   = src_q;

  AST_HOLD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(src_o))); // R8
  AST_PEND_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0 && !valid_o) |=> valid_o); // R8
endmodule

// File: rtl/evsrc_pq_ctrl.sv
module evsrc_pq_ctrl
  import evsrc_pkg::*;
#(
  parameter int                 NUM_SRC    = 8,
  parameter int                 PAGE_SHIFT = 16,
  parameter logic [1:0]         RESET_PQ   = 2'b00,
  parameter bit                 STORE_EOI  = 1'b1,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int                SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int                ADDR_W     = SRC_W + PAGE_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  output logic [2:0]         bus_rdata_o,
  output logic               bus_rvalid_o,
  output logic               notify_valid_o,
  output logic [SRC_W-1:0]   notify_src_o,
  input  logic               notify_ready_i
);
  logic               dec_hit;
  logic [SRC_W-1:0]   dec_src;
  evsrc_op_e          dec_op;
  logic [1:0]         dec_set;
  logic [2:0]         state [NUM_SRC];
  logic [NUM_SRC-1:0] fwd;
  logic [2:0]         rdata_q;
  logic               rvalid_q;

  evsrc_decode #(
    .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT), .STORE_EOI(STORE_EOI),
    .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .hit_o(dec_hit), .src_o(dec_src), .op_o(dec_op), .set_val_o(dec_set)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      evsrc_op_e op_i;
      assign op_i = (dec_src == SRC_W'(i)) ? dec_op : OP_NONE;
      evsrc_cell #(.RESET_PQ(RESET_PQ), .IS_LEVEL(LEVEL_MASK[i])) u_cell (
        .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .set_val_i(dec_set),
        .trig_i(trig_i[i]), .level_i(level_i[i]),
        .state_o(state[i]), .notify_o(fwd[i])
      );
    end
  endgenerate

  evsrc_notify_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .new_i(fwd), .ready_i(notify_ready_i),
    .valid_o(notify_valid_o), .src_o(notify_src_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_req_i && !bus_we_i;
      if (bus_req_i && !bus_we_i) rdata_q <= dec_hit ? state[dec_src] : 3'b000;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  AST_LOAD_ANSWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i) |=> bus_rvalid_o); // R11
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> !bus_rvalid_o); // R11
endmodule

// File: tb/evsrc_pq_ctrl_test.sv
`timescale 1ns/1ps
module evsrc_pq_ctrl_test;
  localparam int N = 8;
  localparam int SH = 16;
  localparam int AW = 19;
  localparam int N2 = 4;
  localparam int SH2 = 13;
  localparam int AW2 = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]  trig = '0, level = '0;
  logic          req = 0, we = 0, rdy = 1;
  logic [AW-1:0] addr = '0;
  logic [2:0]    rdata;
  logic          rvalid, nvalid;
  logic [2:0]    nsrc;

  logic           req2 = 0, we2 = 0;
  logic [AW2-1:0] addr2 = '0;
  logic [2:0]     rdata2;
  logic           rvalid2, nvalid2;
  logic [1:0]     nsrc2;

  evsrc_pq_ctrl #(.NUM_SRC(N), .PAGE_SHIFT(SH), .RESET_PQ(2'b00),
                  .STORE_EOI(1'b1), .LEVEL_MASK(8'h80)) uut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .level_i(level),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .notify_valid_o(nvalid), .notify_src_o(nsrc), .notify_ready_i(rdy));

  evsrc_pq_ctrl #(.NUM_SRC(N2), .PAGE_SHIFT(SH2), .RESET_PQ(2'b01),
                  .STORE_EOI(1'b0), .LEVEL_MASK(4'h0)) uut2 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(4'h0), .level_i(4'h0),
    .bus_req_i(req2), .bus_we_i(we2), .bus_addr_i(addr2),
    .bus_rdata_o(rdata2), .bus_rvalid_o(rvalid2),
    .notify_valid_o(nvalid2), .notify_src_o(nsrc2), .notify_ready_i(1'b1));

  int tests = 0, fails = 0;
  int ncnt [N];
  int n2cnt = 0;
  int log_src [64];
  int lcnt = 0;

  initial for (int i = 0; i < N; i++) ncnt[i] = 0;

  always @(posedge clk) begin
    if (nvalid && rdy) begin
      ncnt[nsrc] = ncnt[nsrc] + 1;
      if (lcnt < 64) log_src[lcnt] = int'(nsrc);
      lcnt = lcnt + 1;
    end
    if (nvalid2) n2cnt = n2cnt + 1;
  end

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] a1(input int src, input int off);
    return AW'((src << SH) | off);
  endfunction

  task automatic ld(input int src, input int off, output logic [2:0] d);
    @(negedge clk); req = 1; we = 0; addr = a1(src, off);
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic st(input int src, input int off);
    @(negedge clk); req = 1; we = 1; addr = a1(src, off);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic ld2(input int a, output logic [2:0] d);
    @(negedge clk); req2 = 1; we2 = 0; addr2 = AW2'(a);
    @(negedge clk); req2 = 0; d = rdata2;
  endtask

  task automatic st2(input int a);
    @(negedge clk); req2 = 1; we2 = 1; addr2 = AW2'(a);
    @(negedge clk); req2 = 0; we2 = 0;
  endtask

  task automatic pulse(input int src);
    @(negedge clk); trig[src] = 1;
    @(negedge clk); trig[src] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [2:0] d;
    chk("R1 notify idle", int'(nvalid), 0);
    for (int i = 0; i < N; i++) begin
      ld(i, 'h800, d);
      chk("R1 reset state", int'(d), 0);
    end
    ld2((1 << SH2) | (1 << 12) | 'h800, d);
    chk("R1 reset value param", int'(d), 1);
  endtask

  task automatic t_trigger;
    logic [2:0] d;
    @(negedge clk); trig[1] = 1;
    @(negedge clk); trig[1] = 0;
    chk("R11 notify not after one edge", int'(nvalid), 0);
    @(negedge clk);
    chk("R11 notify after two edges", int'(nvalid), 1);
    chk("R11 notify src", int'(nsrc), 1);
    idle(3);
    chk("R2 forward from 00", ncnt[1], 1);
    ld(1, 'h800, d); chk("R2 00->10", int'(d), 2);
    pulse(1); ld(1, 'h800, d); chk("R2 10->11", int'(d), 3);
    pulse(1); ld(1, 'h800, d); chk("R2 11 stays", int'(d), 3);
    idle(3); chk("R2 no forward while P", ncnt[1], 1);
    ld(2, 'hD00, d);
    pulse(2); ld(2, 'h800, d); chk("R2 01 stays", int'(d), 1);
    idle(3); chk("R2 01 silent", ncnt[2], 0);
  endtask

  task automatic t_eoi;
    logic [2:0] d;
    ld(1, 'h000, d); chk("R3 eoi returns prior 11", int'(d), 3);
    idle(3); chk("R3 eoi 11 refires", ncnt[1], 2);
    ld(1, 'h800, d); chk("R3 11->10", int'(d), 2);
    ld(1, 'h000, d); chk("R3 eoi returns prior 10", int'(d), 2);
    ld(1, 'h800, d); chk("R4 read 00 after eoi", int'(d), 0);
    idle(3); chk("R3 eoi 10 silent", ncnt[1], 2);
    ld(1, 'h000, d); chk("R3 eoi on 00", int'(d), 0);
    ld(2, 'h000, d); chk("R3 eoi on 01", int'(d), 1);
    ld(2, 'h800, d); chk("R4 01 unchanged", int'(d), 1);
  endtask

  task automatic t_set;
    logic [2:0] d;
    ld(3, 'hF00, d); chk("R5 set11 prior", int'(d), 0);
    ld(3, 'h800, d); chk("R5 state 11", int'(d), 3);
    ld(3, 'hE00, d); chk("R5 set10 prior", int'(d), 3);
    ld(3, 'h800, d); chk("R5 state 10", int'(d), 2);
    ld(3, 'hC00, d); chk("R5 set00 prior", int'(d), 2);
    ld(3, 'h800, d); chk("R5 state 00", int'(d), 0);
    idle(3); chk("R5 set never forwards", ncnt[3], 0);
  endtask

  task automatic t_store;
    logic [2:0] d;
    st(4, 'h800); idle(3);
    chk("R6 inject forwards", ncnt[4], 1);
    ld(4, 'h800, d); chk("R6 inject 00->10", int'(d), 2);
    st(4, 'h400);
    ld(4, 'h800, d); chk("R6 store eoi 10->00", int'(d), 0);
    st(4, 'hC00); st(4, 'h000);
    ld(4, 'h800, d); chk("R12 stores ignored", int'(d), 0);
    idle(3); chk("R12 stores silent", ncnt[4], 1);
    ld(4, 'hF00, d);
    ld(4, 'h400, d); chk("R12 load 0x400 reads", int'(d), 3);
    ld(4, 'h800, d); chk("R12 load 0x400 no change", int'(d), 3);
    ld(4, 'hC00, d);
  endtask

  task automatic t_ready;
    int base;
    base = lcnt;
    @(negedge clk); rdy = 0; trig[6] = 1; trig[5] = 1;
    @(negedge clk); trig[6] = 0; trig[5] = 0;
    @(negedge clk);
    chk("R8 valid with ready low", int'(nvalid), 1);
    chk("R8 lowest first", int'(nsrc), 5);
    idle(4);
    chk("R8 hold valid", int'(nvalid), 1);
    chk("R8 hold src", int'(nsrc), 5);
    rdy = 1;
    idle(4);
    chk("R8 count", lcnt - base, 2);
    chk("R8 order first", log_src[base], 5);
    chk("R8 order second", log_src[base+1], 6);
  endtask

  task automatic t_same;
    logic [2:0] d;
    ld(0, 'hF00, d);
    @(negedge clk); req = 1; we = 0; addr = a1(0, 'hC00); trig[0] = 1;
    @(negedge clk); req = 0; trig[0] = 0; d = rdata;
    chk("R9 access prior", int'(d), 3);
    ld(0, 'h800, d); chk("R9 access first then trigger", int'(d), 2);
    idle(3); chk("R9 trigger forwarded", ncnt[0], 1);
  endtask

  task automatic t_level;
    logic [2:0] d;
    pulse(7); ld(7, 'h800, d); chk("R10 pulse ignored", int'(d), 0);
    @(negedge clk); level[7] = 1;
    idle(3);
    ld(7, 'h800, d); chk("R10 asserted and pending", int'(d), 6);
    chk("R10 rise forwards", ncnt[7], 1);
    ld(7, 'h000, d); chk("R10 eoi prior", int'(d), 6);
    ld(7, 'h800, d); chk("R10 eoi while asserted refires", int'(d), 6);
    idle(3); chk("R10 refire forwarded", ncnt[7], 2);
    @(negedge clk); level[7] = 0;
    idle(1);
    ld(7, 'h800, d); chk("R10 flag clears", int'(d), 2);
    ld(7, 'h000, d);
    ld(7, 'h800, d); chk("R10 eoi after release", int'(d), 0);
    idle(3); chk("R10 no forward after release", ncnt[7], 2);
  endtask

  task automatic t_twopage;
    logic [2:0] d;
    int tp, mp;
    tp = 2 << SH2;
    mp = tp | (1 << 12);
    ld2(mp | 'hC00, d); chk("R7 mgmt set prior", int'(d), 1);
    st2(tp); idle(3);
    chk("R7 trigger page store forwards", n2cnt, 1);
    ld2(tp | 'h800, d); chk("R7 trigger page load reads", int'(d), 2);
    ld2(mp | 'h800, d); chk("R7 mgmt read", int'(d), 2);
    st2(mp | 'h400);
    ld2(mp | 'h800, d); chk("R6 store eoi disabled", int'(d), 2);
    ld2(mp | 'h000, d); chk("R7 mgmt eoi prior", int'(d), 2);
    ld2(mp | 'h800, d); chk("R7 mgmt eoi result", int'(d), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    t_reset;
    t_trigger;
    t_eoi;
    t_set;
    t_store;
    t_ready;
    t_same;
    t_level;
    t_twopage;
    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule